// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block produces the 6-bit word that sets a digital step attenuator. Each bit adds a fixed loss, so the word covers 0 to 31.5 dB in 0.5 dB steps. The word can be loaded in three ways. A three-wire serial port has data, a shift clock and a latch strobe. A latched parallel port captures six pins on a strobe pulse. A direct parallel port lets the pins drive the word without a latch. A mode pin chooses serial or parallel loading.

All control pins are asynchronous to the block. They pass through flop synchronizers into a fast system clock domain, and the shift clock and strobe are edge-detected there. The system clock must run at least eight times faster than the shift clock. When reset is released, the block chooses a starting word from the synchronized pin levels, once. That choice depends on the mode and the strobe level. It holds that word until the first real load event.

Top module: `step_atten_ctrl`

## Requirements
- R1: With `serial_mode_i` high, the parallel pins have no effect on the word after start-up. With it low, parallel loading applies, and a switch from serial to parallel with the strobe high makes the word follow the parallel pins.
- R2: Each rising shift-clock edge shifts `sdata_i` into a 6-bit register at bit 0. The first bit of a frame therefore ends in bit 5, the 16 dB bit, and the last bit ends in bit 0, the 0.5 dB bit.
- R3: Shifting occurs whatever the strobe level is. While the strobe stays low in serial mode, `atten_o` does not change.
- R4: In serial mode, once a strobe rising edge has been seen, `atten_o` follows the shift register while the strobe is high. It keeps its value when the strobe falls.
- R5: In parallel mode, a high-then-low strobe pulse loads the parallel pins. Pin changes while the strobe is low leave `atten_o` unchanged.
- R6: In parallel mode with the strobe held high, `atten_o` equals `par_i` three clock cycles after a change.
- R7: If reset is released in serial mode, the start-up word equals `par_i`, for any of the 64 codes.
- R8: If reset is released in parallel mode with the strobe low, the start-up word comes from `preset_i`, where bit 1 is the second preset pin and bit 0 the first. The codes map as follows: 2'b00 gives 6'b000000, 2'b10 gives 6'b010000 (8 dB), 2'b01 gives 6'b100000 (16 dB) and 2'b11 gives 6'b111111 (31.5 dB).
- R9: If reset is released in parallel mode with the strobe high, `preset_i` is ignored and the start-up word equals `par_i`.
- R10: While reset is asserted, `atten_o` is 0. It stays 0 for two clock edges after release and shows the start-up word after the third edge. `atten_o` bit k weighs 0.5·2^k dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| serial_mode_i | input | 1 | 1 = serial loading, 0 = parallel loading |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| strobe_i | input | 1 | Latch strobe / transparency control |
| par_i | input | 6 | Parallel attenuation word, also the serial start-up word |
| preset_i | input | 2 | Preset select for parallel start-up with the strobe low |
| atten_o | output | 6 | Attenuation word, bit k = 0.5·2^k dB |

## Verification
The bench builds the block with its default parameters: a 6-bit word and two synchronizer stages. With these values all 64 codes can be swept through the serial start-up, direct and latched parallel, and serial frame paths. The fixed three-edge latency from pin to word also lets each check be placed on an exact cycle. All four preset codes are run, and each start-up case pairs a parallel value that differs from the expected word, so taking the wrong source shows up.

// File: rtl/sac_pkg.sv
package sac_pkg;

  // Source chosen for the word on the start-up cycle
  typedef enum logic [1:0] {
    BOOT_FROM_PINS   = 2'd0,
    BOOT_FROM_PRESET = 2'd1
  } boot_src_e;

  // Preset start-up word: sel[1] picks the second-highest bit, sel[0] the
  // highest bit, both together give all ones.
  function automatic logic [31:0] preset_code(input logic [1:0] sel,
                                              input int unsigned width);
    logic [31:0] ones;
    ones = (32'd1 << width) - 32'd1;
    case (sel)
      2'b00:   preset_code = 32'd0;
      2'b10:   preset_code = 32'd1 << (width - 2);
      2'b01:   preset_code = 32'd1 << (width - 1);
      default: preset_code = ones;
    endcase
  endfunction

endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sac_shift.sv
module sac_shift #(
  parameter int unsigned WORD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  output logic              sclk_rise_o,
  output logic [WORD_W-1:0] shreg_o
);
  logic              sclk_d_q;
  logic [WORD_W-1:0] shreg_q;

  assign sclk_rise_o = enable_i && sclk_s_i && !sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      shreg_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      if (sclk_rise_o) shreg_q <= {shreg_q[WORD_W-2:0], sdata_s_i};
    end
  end

  assign shreg_o = shreg_q;

  // R2: a detected edge moves the register up one place and inserts the data bit
  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_o |=> (shreg_q == {$past(shreg_q[WORD_W-2:0]), $past(sdata_s_i)}));

  // R3: without a shift-clock edge the register keeps its contents
  p_no_edge_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise_o |=> $stable(shreg_q));
endmodule

// File: rtl/sac_word.sv
module sac_word
  import sac_pkg::*;
#(
  parameter int unsigned WORD_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_s_i,
  input  logic              strobe_s_i,
  input  logic [WORD_W-1:0] par_s_i,
  input  logic [1:0]        preset_s_i,
  input  logic [WORD_W-1:0] shreg_i,
  output logic              booted_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] BOOT_AT = CNT_W'(SYNC_STAGES);

  logic [CNT_W-1:0]  cnt_q;
  logic              booted_q, strobe_d_q, strobe_seen_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              boot_fire, strobe_rise, serial_open, direct_open;
  boot_src_e         boot_src;

  assign boot_fire   = !booted_q && (cnt_q == BOOT_AT);
  assign strobe_rise = booted_q && strobe_s_i && !strobe_d_q;
  assign boot_src    = (!mode_s_i && !strobe_s_i) ? BOOT_FROM_PRESET : BOOT_FROM_PINS;
  assign serial_open = booted_q && mode_s_i && strobe_s_i && (strobe_seen_q || strobe_rise);
  assign direct_open = booted_q && !mode_s_i && strobe_s_i;

  always_comb begin
    word_d = word_q;
    if (boot_fire) begin
      if (boot_src == BOOT_FROM_PRESET) word_d = WORD_W'(preset_code(preset_s_i, WORD_W));
      else                              word_d = par_s_i;
    end else if (direct_open) begin
      word_d = par_s_i;
    end else if (serial_open) begin
      word_d = shreg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      booted_q      <= 1'b0;
      strobe_d_q    <= 1'b0;
      strobe_seen_q <= 1'b0;
      word_q        <= '0;
    end else begin
      if (!booted_q && (cnt_q != BOOT_AT)) cnt_q <= cnt_q + 1'b1;
      booted_q   <= booted_q | boot_fire;
      strobe_d_q <= strobe_s_i;
      if (!mode_s_i)        strobe_seen_q <= 1'b0;
      else if (strobe_rise) strobe_seen_q <= 1'b1;
      word_q <= word_d;
    end
  end

  assign booted_o = booted_q;
  assign word_o   = word_q;

  // R3/R5: with the strobe low the word is frozen after start-up
  p_hold_strobe_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted_q && !strobe_s_i) |=> (word_q == $past(word_q)));

  // R6: direct parallel tracks the synchronized pins one edge later
  p_direct_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted_q && !mode_s_i && strobe_s_i) |=> (word_q == $past(par_s_i)));

  // R4: once opened, serial transparency copies the shift register
  p_serial_transp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted_q && mode_s_i && strobe_s_i && strobe_seen_q) |=> (word_q == $past(shreg_i)));

  // R7: serial start-up takes the parallel pins
  p_boot_serial_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_fire && mode_s_i) |=> (word_q == $past(par_s_i)));

  // R8: parallel start-up with strobe low never takes a non-preset value
  p_boot_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_fire && !mode_s_i && !strobe_s_i) |=>
      ($countones(word_q) <= 1 || word_q == '1));

  // R10: start-up happens once and stays done
  p_boot_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    booted_q |=> (booted_q && !boot_fire));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int unsigned WORD_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_mode_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              strobe_i,
  input  logic [WORD_W-1:0] par_i,
  input  logic [1:0]        preset_i,
  output logic [WORD_W-1:0] atten_o
);
  localparam int unsigned BUS_W = WORD_W + 6;

  logic [BUS_W-1:0]  raw_bus, sync_bus;
  logic              mode_s, sclk_s, sdata_s, strobe_s;
  logic [WORD_W-1:0] par_s, shreg;
  logic [1:0]        preset_s;
  logic              sclk_rise, booted;

  assign raw_bus = {preset_i, par_i, strobe_i, sdata_i, sclk_i, serial_mode_i};

  sac_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  assign mode_s   = sync_bus[0];
  assign sclk_s   = sync_bus[1];
  assign sdata_s  = sync_bus[2];
  assign strobe_s = sync_bus[3];
  assign par_s    = sync_bus[4 +: WORD_W];
  assign preset_s = sync_bus[BUS_W-1 -: 2];

  sac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (booted),
    .sclk_s_i   (sclk_s),
    .sdata_s_i  (sdata_s),
    .sclk_rise_o(sclk_rise),
    .shreg_o    (shreg)
  );

  sac_word #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_word (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_s_i  (mode_s),
    .strobe_s_i(strobe_s),
    .par_s_i   (par_s),
    .preset_s_i(preset_s),
    .shreg_i   (shreg),
    .booted_o  (booted),
    .word_o    (atten_o)
  );

  // R2/R3: shifting is only possible after start-up
  p_shift_after_boot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |-> booted);

  // R1: in serial mode with strobe low the word ignores every pin
  p_serial_ignores_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted && mode_s && !strobe_s) |=> $stable(atten_o));
endmodule

// File: tb/step_atten_ctrl_tb_top.sv
module step_atten_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode = 1'b0, sclk = 1'b0, sdata = 1'b0, strobe = 1'b0;
  logic [5:0] par = '0;
  logic [1:0] preset = '0;
  logic [5:0] atten;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  step_atten_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .serial_mode_i(mode), .sclk_i(sclk),
    .sdata_i(sdata), .strobe_i(strobe), .par_i(par), .preset_i(preset),
    .atten_o(atten)
  );

  function automatic logic [5:0] exp_preset(input logic [1:0] sel);
    int db2;  // loss in half-dB units
    db2 = (sel == 2'b11) ? 63 : (sel == 2'b01) ? 32 : (sel == 2'b10) ? 16 : 0;
    return 6'(db2);
  endfunction

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: atten=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic s, input logic [5:0] p,
                          input logic [1:0] pr, input logic [5:0] exp_boot,
                          input string req);
    @(negedge clk);
    rst_ni = 1'b0; mode = m; strobe = s; par = p; preset = pr; sclk = 1'b0;
    clks(3);
    chk("R10 in reset", atten, 6'd0);
    rst_ni = 1'b1;
    clks(2);
    chk("R10 two edges after release", atten, 6'd0);
    clks(1);
    chk(req, atten, exp_boot);
  endtask

  task automatic shift_frame(input logic [5:0] code);
    for (int i = 5; i >= 0; i--) begin
      sdata = code[i];
      clks(4);
      sclk = 1'b1;
      clks(4);
      sclk = 1'b0;
    end
    clks(4);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; clks(4);
    strobe = 1'b0; clks(4);
  endtask

  initial begin
    logic [5:0] prev;
    // R7: serial start-up takes any parallel code
    for (int c = 0; c < 64; c++) do_reset(1'b1, 1'b0, 6'(c), 2'(c), 6'(c), "R7 serial boot");
    // R8: preset table, with pins set to the inverse to expose wrong source
    for (int k = 0; k < 4; k++)
      do_reset(1'b0, 1'b0, ~exp_preset(2'(k)), 2'(k), exp_preset(2'(k)), "R8 preset boot");
    // R10: preset word is held while the pins move with strobe low
    par = 6'd21; clks(6);
    chk("R10 boot word held", atten, exp_preset(2'b11));
    // R9: strobe high at start-up ignores the presets
    do_reset(1'b0, 1'b1, 6'd5, 2'b11, 6'd5, "R9 direct boot");
    do_reset(1'b0, 1'b1, 6'd40, 2'b01, 6'd40, "R9 direct boot");

    // R6: direct parallel, every code, three-edge latency
    for (int c = 0; c < 64; c++) begin
      par = 6'(c);
      clks(2);
      if (c > 0) chk("R6 before latency", atten, 6'(c - 1));
      clks(1);
      chk("R6 direct follow", atten, 6'(c));
    end

    // R5: latched parallel
    strobe = 1'b0; clks(4);
    prev = atten;
    for (int c = 0; c < 64; c++) begin
      par = 6'(c); clks(5);
      chk("R5 no load without pulse", atten, prev);
      pulse_strobe();
      chk("R5 latched load", atten, 6'(c));
      par = ~6'(c); clks(5);
      chk("R5 hold after fall", atten, 6'(c));
      prev = 6'(c);
    end

    // R1/R3/R4/R2: serial frames
    do_reset(1'b1, 1'b0, 6'd0, 2'b00, 6'd0, "R7 serial boot zero");
    par = 6'd63; clks(6);
    chk("R1 parallel pins ignored in serial", atten, 6'd0);
    prev = 6'd0;
    for (int c = 0; c < 64; c++) begin
      logic [5:0] code;
      code = 6'(c * 37 + 11);
      shift_frame(code);
      chk("R3 shift with strobe low holds word", atten, prev);
      pulse_strobe();
      chk("R2 R4 frame latched MSB first", atten, code);
      prev = code;
    end
    // R4: transparent while high, held after fall
    strobe = 1'b1; clks(4);
    shift_frame(6'b101101);
    chk("R4 transparent while high", atten, 6'b101101);
    strobe = 1'b0; clks(4);
    shift_frame(6'b010011);
    chk("R4 held after fall", atten, 6'b101101);
    // R1: switching to parallel with strobe high follows the pins
    par = 6'd27; mode = 1'b0; strobe = 1'b1; clks(5);
    chk("R1 parallel after mode switch", atten, 6'd27);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule